// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two IEEE-754 operands and turns the result into a four-bit condition nibble laid out as N, Z, C, V. The operands can be double precision (the full 64-bit word) or single precision (the low 32 bits of each word). Each compare lands in one of four relations: equal, less, greater or unordered. Each relation maps to one fixed nibble. Unordered means at least one operand is a NaN.

A mode input picks between a quiet compare and a signalling compare. Both modes give the same nibble. They differ only in when the invalid-operation output rises. A quiet compare raises it only for a signalling NaN. A signalling compare raises it for any NaN.

The inputs are sampled on every rising clock edge and both results are registered. A core pipeline stage can therefore issue one compare per cycle and pick up the flags one cycle later.

Top module: `fpcmp_flags`

## Requirements
- R1: When the operands are equal, the nibble is 4'b0110 (bit 3 N=0, bit 2 Z=1, bit 1 C=1, bit 0 V=0).
- R2: When operand A is less than operand B, the nibble is 4'b1000 (only N set).
- R3: When operand A is greater than operand B, the nibble is 4'b0010 (only C set).
- R4: When either operand is a NaN (exponent all ones, fraction non-zero), the nibble is 4'b0011 (C and V set).
- R5: With `dbl_sel`=1 the full 64-bit words are compared as double precision (11-bit exponent at [62:52], fraction at [51:0]). With `dbl_sel`=0 only bits [31:0] are compared as single precision (8-bit exponent at [30:23], fraction at [22:0]), and bits [63:32] have no effect.
- R6: With `sig_cmp`=0 (quiet), `invalid` is 1 only if at least one operand is a signalling NaN.
- R7: With `sig_cmp`=1 (signalling), `invalid` is 1 whenever at least one operand is a NaN of either kind.
- R8: Positive zero and negative zero compare equal in both orders.
- R9: Operands that are not NaN are ordered by sign and magnitude. Any negative value is less than any positive value. Between two positives the larger magnitude is greater. Between two negatives the larger magnitude is less. The infinities are the extremes.
- R10: A NaN is signalling when the top fraction bit (bit 51 for double, bit 22 for single) is 0, and quiet when that bit is 1.
- R11: `nzcv` and `invalid` are registered. They reflect the inputs sampled at the previous rising edge, and a synchronous active-high `rst` clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | Operand A word (single precision in [31:0]) |
| op_b | input | 64 | Operand B word (single precision in [31:0]) |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| sig_cmp | input | 1 | 1 = signalling compare, 0 = quiet compare |
| nzcv | output | 4 | Condition nibble {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation flag for this compare |

## Verification
The flag nibble and the invalid flag are both due exactly one rising edge after the operands and mode bits are sampled. Nothing in the block carries over from one compare to the next.

The bench drives each new compare on a falling edge and computes the expected pair into a queue. At the next falling edge, after the capturing rising edge, it pops that entry and compares it with the outputs. A one-cycle offset in either output therefore shows up as a mismatch on the following vector.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  // Condition nibble codes, bit order {N,Z,C,V}
  localparam logic [3:0] FLAGS_EQ = 4'b0110;
  localparam logic [3:0] FLAGS_LT = 4'b1000;
  localparam logic [3:0] FLAGS_GT = 4'b0010;
  localparam logic [3:0] FLAGS_UN = 4'b0011;

endpackage

// File: rtl/fpcmp_classify.sv
// Unpacks one IEEE-754 word into sign, magnitude and NaN class.
module fpcmp_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int MAG_W  = 63
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [MAG_W-1:0]      mag,
  output logic                  is_nan,
  output logic                  is_snan
);
  localparam int SRC_MAG_W = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;

  assign sign     = word[SRC_MAG_W];
  assign exp_f    = word[SRC_MAG_W-1:FRAC_W];
  assign frac_f   = word[FRAC_W-1:0];
  assign exp_ones = &exp_f;

  // Magnitude zero-extended to the common compare width
  always_comb begin
    mag                = '0;
    mag[SRC_MAG_W-1:0] = word[SRC_MAG_W-1:0];
  end

  assign is_nan  = exp_ones && (|frac_f);
  assign is_snan = is_nan && !frac_f[FRAC_W-1];
endmodule

// File: rtl/fpcmp_order.sv
// Four-way relation between two classified operands.
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             any_nan,
  output rel_e             rel
);
  logic both_zero;
  logic mag_eq;
  logic mag_gt;

  assign both_zero = (mag_a == '0) && (mag_b == '0);
  assign mag_eq    = (mag_a == mag_b);
  assign mag_gt    = (mag_a > mag_b);

  always_comb begin
    if (any_nan) begin
      rel = REL_UN;
    end else if (both_zero) begin
      rel = REL_EQ;
    end else if (sign_a != sign_b) begin
      rel = sign_a ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else if (mag_gt ^ sign_a) begin
      rel = REL_GT;
    end else begin
      rel = REL_LT;
    end
  end
endmodule

// File: rtl/fpcmp_encode.sv
// Maps relation to condition nibble and decides the invalid flag.
module fpcmp_encode
  import fpcmp_pkg::*;
(
  input  rel_e       rel,
  input  logic       sig_mode,
  input  logic       any_nan,
  input  logic       any_snan,
  output logic [3:0] flags,
  output logic       inv
);
  always_comb begin
    unique case (rel)
      REL_EQ:  flags = FLAGS_EQ;
      REL_LT:  flags = FLAGS_LT;
      REL_GT:  flags = FLAGS_GT;
      default: flags = FLAGS_UN;
    endcase
  end

  assign inv = sig_mode ? any_nan : any_snan;
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
  import fpcmp_pkg::*;
#(
  parameter int D_EXP_W  = 11,
  parameter int D_FRAC_W = 52,
  parameter int S_EXP_W  = 8,
  parameter int S_FRAC_W = 23
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [D_EXP_W+D_FRAC_W:0]  op_a,
  input  logic [D_EXP_W+D_FRAC_W:0]  op_b,
  input  logic                       dbl_sel,
  input  logic                       sig_cmp,
  output logic [3:0]                 nzcv,
  output logic                       invalid
);
  localparam int WORD_W = 1 + D_EXP_W + D_FRAC_W;
  localparam int S_WORD = 1 + S_EXP_W + S_FRAC_W;
  localparam int MAG_W  = WORD_W - 1;
  localparam int N_OPS  = 2;

  logic [WORD_W-1:0] opw       [N_OPS];
  logic              c_sign    [N_OPS];
  logic [MAG_W-1:0]  c_mag     [N_OPS];
  logic              c_nan     [N_OPS];
  logic              c_snan    [N_OPS];

  assign opw[0] = op_a;
  assign opw[1] = op_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    logic             d_sign, s_sign;
    logic [MAG_W-1:0] d_mag, s_mag;
    logic             d_nan, s_nan, d_snan, s_snan;

    fpcmp_classify #(
      .EXP_W (D_EXP_W), .FRAC_W(D_FRAC_W), .MAG_W(MAG_W)
    ) u_dbl (
      .word(opw[g]), .sign(d_sign), .mag(d_mag),
      .is_nan(d_nan), .is_snan(d_snan)
    );

    fpcmp_classify #(
      .EXP_W (S_EXP_W), .FRAC_W(S_FRAC_W), .MAG_W(MAG_W)
    ) u_sgl (
      .word(opw[g][S_WORD-1:0]), .sign(s_sign), .mag(s_mag),
      .is_nan(s_nan), .is_snan(s_snan)
    );

    assign c_sign[g] = dbl_sel ? d_sign : s_sign;
    assign c_mag[g]  = dbl_sel ? d_mag  : s_mag;
    assign c_nan[g]  = dbl_sel ? d_nan  : s_nan;
    assign c_snan[g] = dbl_sel ? d_snan : s_snan;
  end

  logic       any_nan, any_snan;
  rel_e       rel;
  logic [3:0] flags_d;
  logic       inv_d;

  assign any_nan  = c_nan[0]  | c_nan[1];
  assign any_snan = c_snan[0] | c_snan[1];

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .sign_a (c_sign[0]), .mag_a(c_mag[0]),
    .sign_b (c_sign[1]), .mag_b(c_mag[1]),
    .any_nan(any_nan),   .rel  (rel)
  );

  fpcmp_encode u_encode (
    .rel     (rel),
    .sig_mode(sig_cmp),
    .any_nan (any_nan),
    .any_snan(any_snan),
    .flags   (flags_d),
    .inv     (inv_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nzcv    <= '0;
      invalid <= 1'b0;
    end else begin
      nzcv    <= flags_d;
      invalid <= inv_d;
    end
  end
endmodule

// File: rtl/fpcmp_flags_chk.sv
module fpcmp_flags_chk (
  input logic        clk,
  input logic        rst,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        dbl_sel,
  input logic        sig_cmp,
  input logic [3:0]  nzcv,
  input logic        invalid
);
  // Set once the outputs hold a computed compare
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  // R11: reset clears outputs
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (nzcv == 4'b0000 && !invalid));

  // R1 R2 R3 R4: only the four legal nibbles appear
  p_legal_code_r4: assert property (@(posedge clk) disable iff (rst)
    live |-> (nzcv == 4'b0110 || nzcv == 4'b1000 ||
              nzcv == 4'b0010 || nzcv == 4'b0011));

  // R6 R7: invalid only accompanies an unordered result
  p_invalid_unordered_r6: assert property (@(posedge clk) disable iff (rst)
    invalid |-> nzcv == 4'b0011);

  // R7: signalling compare always flags an unordered result
  p_sig_invalid_r7: assert property (@(posedge clk) disable iff (rst)
    (live && $past(sig_cmp) && nzcv == 4'b0011) |-> invalid);

  // R1: identical non-NaN double words compare equal
  p_same_dbl_r1: assert property (@(posedge clk) disable iff (rst)
    (live && $past(dbl_sel && op_a == op_b && op_a[62:52] != 11'h7ff))
      |-> nzcv == 4'b0110);

  // R5: identical low single words compare equal whatever the upper halves
  p_same_sgl_r5: assert property (@(posedge clk) disable iff (rst)
    (live && $past(!dbl_sel && op_a[31:0] == op_b[31:0] && op_a[30:23] != 8'hff))
      |-> nzcv == 4'b0110);
endmodule

bind fpcmp_flags fpcmp_flags_chk u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
  .dbl_sel(dbl_sel), .sig_cmp(sig_cmp), .nzcv(nzcv), .invalid(invalid)
);

// File: tb/fpcmp_flags_test.sv
module fpcmp_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic        dbl_sel = 1'b1, sig_cmp = 1'b0;
  logic [3:0]  nzcv;
  logic        invalid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcmp_flags uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .dbl_sel(dbl_sel), .sig_cmp(sig_cmp), .nzcv(nzcv), .invalid(invalid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Behavioural reference: signed ordering key per operand
  function automatic logic [4:0] model(input logic [63:0] a, input logic [63:0] b,
                                       input logic dbl, input logic sig);
    logic [63:0] w[2];
    logic nan[2], snan[2];
    longint key[2];
    w[0] = a; w[1] = b;
    for (int i = 0; i < 2; i++) begin
      longint m;
      if (dbl) begin
        nan[i]  = (w[i][62:52] == 11'h7ff) && (w[i][51:0] != 0);
        snan[i] = nan[i] && !w[i][51];
        m       = longint'({1'b0, w[i][62:0]});
        key[i]  = w[i][63] ? -m : m;
      end else begin
        nan[i]  = (w[i][30:23] == 8'hff) && (w[i][22:0] != 0);
        snan[i] = nan[i] && !w[i][22];
        m       = longint'({33'd0, w[i][30:0]});
        key[i]  = w[i][31] ? -m : m;
      end
    end
    if (nan[0] || nan[1])
      return {4'b0011, sig ? 1'b1 : (snan[0] || snan[1])};
    else if (key[0] == key[1]) return {4'b0110, 1'b0};
    else if (key[0] <  key[1]) return {4'b1000, 1'b0};
    else                       return {4'b0010, 1'b0};
  endfunction

  task automatic check_front();
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({nzcv, invalid} !== e) begin
        errors++;
        $display("FAIL %s: nzcv=%b invalid=%b expected nzcv=%b invalid=%b",
                 t, nzcv, invalid, e[4:1], e[0]);
      end
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic dbl, input logic sig, input string tag);
    @(negedge clk);
    check_front();
    rst = 1'b0;
    op_a = a; op_b = b; dbl_sel = dbl; sig_cmp = sig;
    exp_q.push_back(model(a, b, dbl, sig));
    tag_q.push_back(tag);
  endtask

  localparam logic [63:0] D_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] D_TWO  = 64'h4000000000000000;
  localparam logic [63:0] D_MONE = 64'hBFF0000000000000;
  localparam logic [63:0] D_MTWO = 64'hC000000000000000;
  localparam logic [63:0] D_PZ   = 64'h0000000000000000;
  localparam logic [63:0] D_NZ   = 64'h8000000000000000;
  localparam logic [63:0] D_PINF = 64'h7FF0000000000000;
  localparam logic [63:0] D_NINF = 64'hFFF0000000000000;
  localparam logic [63:0] D_QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] D_SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] D_SNAN2= 64'hFFF4000000000000;

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (nzcv !== 4'b0000 || invalid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: nzcv=%b invalid=%b expected nzcv=0000 invalid=0", nzcv, invalid);
    end

    apply(D_ONE,  D_ONE,  1, 0, "R1 double equal");
    apply(D_ONE,  D_TWO,  1, 0, "R2 double less");
    apply(D_TWO,  D_ONE,  1, 1, "R3 double greater");
    apply(D_MTWO, D_MONE, 1, 0, "R9 negatives reversed");
    apply(D_MONE, D_MTWO, 1, 0, "R9 negative greater");
    apply(D_MONE, D_ONE,  1, 0, "R9 sign order");
    apply(D_NINF, D_MTWO, 1, 0, "R9 minus infinity");
    apply(D_PINF, D_TWO,  1, 1, "R9 plus infinity");
    apply(D_PZ,   D_NZ,   1, 0, "R8 +0 vs -0");
    apply(D_NZ,   D_PZ,   1, 1, "R8 -0 vs +0");
    apply(D_PZ,   D_MONE, 1, 0, "R9 zero vs negative");
    apply(D_QNAN, D_ONE,  1, 0, "R4 R6 quiet qnan no invalid");
    apply(D_ONE,  D_QNAN, 1, 1, "R4 R7 signalling qnan invalid");
    apply(D_SNAN, D_ONE,  1, 0, "R6 R10 quiet snan invalid");
    apply(D_TWO,  D_SNAN2,1, 0, "R10 negative snan");
    apply(D_QNAN, D_SNAN, 1, 1, "R7 both nan");
    apply(D_PINF, D_PINF, 1, 0, "R1 equal infinities");
    // single precision
    apply(64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 0, 0, "R5 single less");
    apply(64'h7FF8_0000_3F80_0000, 64'h1234_5678_3F80_0000, 0, 0, "R5 upper bits ignored");
    apply(64'hFFFF_FFFF_4000_0000, 64'h0000_0000_3F80_0000, 0, 1, "R5 single greater");
    apply(64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, 0, 0, "R5 R9 single sign");
    apply(64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, 0, 0, "R5 R6 single qnan");
    apply(64'h0000_0000_7F80_0001, 64'h0000_0000_3F80_0000, 0, 0, "R5 R10 single snan");
    apply(64'h0000_0000_3F80_0000, 64'h0000_0000_7FC0_0000, 0, 1, "R5 R7 single qnan sig");
    apply(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, 0, 0, "R8 single zeros");
    apply(64'h0000_0000_7F80_0000, 64'h0000_0000_7F80_0000, 0, 1, "R5 single inf equal");
    apply(D_PINF, 64'h0000_0000_7F80_0000, 1, 0, "R5 double view of single inf");
    // Sweep of adjacent magnitudes, both signs
    for (int k = 0; k < 8; k++) begin
      logic [63:0] x;
      x = 64'h3FF0000000000000 + 64'(k);
      apply(x, x + 64'd1, 1, k[0], "R9 adjacent positive");
      apply(x | 64'h8000000000000000, (x + 64'd1) | 64'h8000000000000000, 1, 0,
            "R9 adjacent negative");
    end
    @(negedge clk);
    check_front();
    // R11: synchronous reset mid-run clears outputs
    rst = 1'b1;
    op_a = D_QNAN; op_b = D_ONE; sig_cmp = 1'b1; dbl_sel = 1'b1;
    @(negedge clk);
    checks++;
    if (nzcv !== 4'b0000 || invalid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset mid-run: nzcv=%b invalid=%b expected nzcv=0000 invalid=0",
               nzcv, invalid);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule